// File: doc/BRIEF.md
# Programmable Watchdog with Recovery-Source Select

This block is a watchdog timer set up through two small write-only control registers, with a readback path. Software writes a 4-bit timeout code. The code sets the expiry period in steps of two seconds, and a code of zero switches the watchdog off. A reload control starts the running count again from the full period. When the count runs out, the block raises a sticky alarm and a one-cycle expiry pulse, then stops counting.

The block also keeps a recovery-source selection that the rest of the system reads after a restart caused by a timeout:
- 0 means the hardware strap settings.
- 1 means the last values programmed by software.

Guarded arming protects the selection against stray writes. It only becomes 1 when software writes a 0 and then a 1.

A built-in prescaler divides the input clock down to one-second ticks. The parameter `TICK_CYCLES` sets the clock cycles per second. A bench can make it small to shorten simulated time.

Top module: `wdog_recover`

## Requirements
- R1: After a write of a non-zero timeout code P to register 0 (`cfg_wdata[3:0]`), `wd_expire` goes high exactly 2·P·`TICK_CYCLES` clock cycles after the write edge, with no further write in between.
- R2: When the timeout code is 0, no expiry ever occurs. A reload write has no effect in that state.
- R3: `wd_alarm` sets on expiry. It stays set through reloads and through rewrites with a non-zero code. It clears only when a timeout code of 0 is written.
- R4: Writing register 1 with bit 0 = 1 restarts the count from the full period, and counting continues. Writing bit 0 = 0 leaves the count untouched.
- R5: `recov_sel` is 1 (software values) only while recovery is armed. A write of 0 to register 1 bit 1 drops it to 0 (strap settings).
- R6: A write of 1 to register 1 bit 1 arms recovery only if an earlier write of 0 to that bit has happened since reset. Otherwise `recov_sel` stays 0.
- R7: After reset:
  - all outputs are 0;
  - both registers read back 0.
- R8: Readback, selected by `cfg_addr`:
  - Register 0 returns the timeout code in bits [3:0] and the alarm in bit 4.
  - Register 1 returns the recovery bit in bit 1.
  - The reload bit (bit 0) always reads 0.
- R9: `wd_expire` lasts one cycle. After expiry the count stops, and no further pulse occurs until a reload or a non-zero code write.
- R10: Writing a new non-zero timeout code, even while the count is running, restarts the count with the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 timeout, 1 control |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Readback of the selected register |
| wd_alarm | output | 1 | Sticky timeout flag |
| recov_sel | output | 1 | Recovery source: 1 software values, 0 straps |
| wd_expire | output | 1 | One-cycle expiry pulse |

## Verification
The bench targets the following corner cases:
- **Expiry cycle at both ends of the code range.** A prescaler or period off by one would move the pulse by one tick and would be reported against the exact expected cycle.
- **Reload in mid-count and reload-zero writes.** A design that ignores reload, or reloads on a zero bit, pulses at the wrong cycle.
- **Code rewrites while alarmed.** A design that clears the alarm on any write would show the flag low.
- **Reload while switched off.** A design that ignores the off state would emit a pulse that no expectation matches.
- **Recovery arming after reset.** Writing 1 twice without a 0 must leave the selection at strap. A design that arms on any 1 would show `recov_sel` high too early.

// File: rtl/wdog_recover.sv
module wdog_recover #(
  parameter int TICK_CYCLES = 100_000_000,
  parameter int STEP_SEC    = 2,
  parameter int PERIOD_W    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  output logic       wd_alarm,
  output logic       recov_sel,
  output logic       wd_expire
);

  localparam int CNT_W = $clog2(STEP_SEC * ((1 << PERIOD_W) - 1) + 1);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [PERIOD_W-1:0] period_q;
  logic [CNT_W-1:0]    remain_q;
  logic [PRE_W-1:0]    pre_q;
  logic                run_q, rec_bit_q, zero_seen_q, armed_q;

  wire                wr_tmo    = cfg_we & ~cfg_addr;
  wire                wr_ctl    = cfg_we & cfg_addr;
  wire [PERIOD_W-1:0] new_per   = cfg_wdata[PERIOD_W-1:0];
  wire                stop      = wr_tmo && (new_per == '0);
  wire                restart   = (wr_tmo && new_per != '0) ||
                                  (wr_ctl && cfg_wdata[0] && period_q != '0);
  wire [PERIOD_W-1:0] start_per = wr_tmo ? new_per : period_q;
  wire [CNT_W-1:0]    full      = CNT_W'(STEP_SEC) * CNT_W'(start_per);
  wire                tick      = pre_q == PRE_W'(TICK_CYCLES - 1);

  assign recov_sel = armed_q;
  assign cfg_rdata = cfg_addr ? {6'b0, rec_bit_q, 1'b0}
                              : 8'({wd_alarm, period_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q  <= '0;
      remain_q  <= '0;
      pre_q     <= '0;
      run_q     <= 1'b0;
      wd_alarm  <= 1'b0;
      wd_expire <= 1'b0;
    end else begin
      wd_expire <= 1'b0;
      if (wr_tmo) period_q <= new_per;
      if (stop) begin
        run_q    <= 1'b0;
        wd_alarm <= 1'b0;
        remain_q <= '0;
        pre_q    <= '0;
      end else if (restart) begin
        run_q    <= 1'b1;
        remain_q <= full;
        pre_q    <= '0;
      end else if (run_q) begin
        if (tick) begin
          pre_q <= '0;
          if (remain_q == CNT_W'(1)) begin
            run_q     <= 1'b0;
            remain_q  <= '0;
            wd_alarm  <= 1'b1;
            wd_expire <= 1'b1;
          end else begin
            remain_q <= remain_q - 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_bit_q   <= 1'b0;
      zero_seen_q <= 1'b0;
      armed_q     <= 1'b0;
    end else if (wr_ctl) begin
      rec_bit_q <= cfg_wdata[1];
      if (cfg_wdata[1]) begin
        armed_q <= armed_q | zero_seen_q;
      end else begin
        armed_q     <= 1'b0;
        zero_seen_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdog_recover_chk.sv
module wdog_recover_chk #(
  parameter int PERIOD_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we,
  input logic                cfg_addr,
  input logic [7:0]          cfg_wdata,
  input logic                wd_alarm,
  input logic                recov_sel,
  input logic                wd_expire,
  input logic [PERIOD_W-1:0] period_q
);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !wd_expire);

  a_r3_alarm_rises_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_alarm) |-> wd_expire);

  a_r3_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_alarm && !(cfg_we && !cfg_addr && cfg_wdata[PERIOD_W-1:0] == '0)) |=> wd_alarm);

  a_r2_off_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |-> period_q != '0);

  a_r6_arm_by_write_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recov_sel) |-> $past(cfg_we && cfg_addr && cfg_wdata[1]));

  a_r5_zero_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr && !cfg_wdata[1]) |=> !recov_sel);

endmodule

bind wdog_recover wdog_recover_chk #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .wd_alarm(wd_alarm), .recov_sel(recov_sel),
  .wd_expire(wd_expire), .period_q(period_q)
);

// File: tb/wdog_recover_tb.sv
module wdog_recover_tb;
  localparam int T = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       wd_alarm, recov_sel, wd_expire;

  int checks = 0, fails = 0, cyc = 0, last_w = 0;
  bit done = 0;
  int exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_recover #(.TICK_CYCLES(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wd_alarm(wd_alarm),
    .recov_sel(recov_sel), .wd_expire(wd_expire)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    last_w = cyc;
  endtask

  task automatic expect_restart(input int p);
    exp_q.delete();
    exp_q.push_back(last_w + 2 * p * T);
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && wd_expire) begin
      if (exp_q.size() == 0) chk(0, "R2/R9 unexpected pulse", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R1 expiry cycle", cyc, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, v); chk(v == 0, "R7 reg0", v, 0);
    rd(1, v); chk(v == 0, "R7 reg1", v, 0);
    chk({wd_alarm, recov_sel, wd_expire} == 0, "R7 outputs", {wd_alarm, recov_sel, wd_expire}, 0);

    wr(1, 8'h03);
    rd(1, v); chk(v == 8'h02, "R8 reload reads 0", v, 2);
    chk(recov_sel == 0, "R6 one without zero", recov_sel, 0);
    wr(1, 8'h02);
    chk(recov_sel == 0, "R6 second one", recov_sel, 0);
    wr(1, 8'h00);
    chk(recov_sel == 0, "R5 zero written", recov_sel, 0);
    wr(1, 8'h02);
    chk(recov_sel == 1, "R6 armed after 0 then 1", recov_sel, 1);
    wr(1, 8'h00);
    chk(recov_sel == 0, "R5 disarm", recov_sel, 0);
    wr(1, 8'h02);
    chk(recov_sel == 1, "R5 rearm", recov_sel, 1);

    wr(0, 8'h01); expect_restart(1);
    idle(30);
    chk(wd_alarm == 1, "R3 alarm set", wd_alarm, 1);
    rd(0, v); chk(v == 8'h11, "R8 reg0 readback", v, 8'h11);
    chk(exp_q.size() == 0, "R9 one pulse then stop", exp_q.size(), 0);

    wr(0, 8'h03); expect_restart(3);
    chk(wd_alarm == 1, "R3 kept on rewrite", wd_alarm, 1);
    idle(10);
    wr(1, 8'h02);
    idle(40);
    chk(exp_q.size() == 0, "R4 reload zero no effect", exp_q.size(), 0);

    wr(1, 8'h03); expect_restart(3);
    idle(10);
    wr(1, 8'h03); expect_restart(3);
    idle(10);
    wr(0, 8'h02); expect_restart(2);
    idle(40);
    chk(exp_q.size() == 0, "R4 R10 restarts", exp_q.size(), 0);
    chk(wd_alarm == 1, "R3 kept on reload", wd_alarm, 1);

    wr(0, 8'h00); exp_q.delete();
    chk(wd_alarm == 0, "R3 cleared by zero code", wd_alarm, 0);
    rd(0, v); chk(v == 0, "R3 reg0 after clear", v, 0);
    wr(1, 8'h03);
    idle(200);
    chk(wd_alarm == 0, "R2 off stays quiet", wd_alarm, 0);

    wr(0, 8'h0F); expect_restart(15);
    idle(130);
    chk(exp_q.size() == 0, "R1 max period", exp_q.size(), 0);
    chk(recov_sel == 1, "R5 selection held", recov_sel, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule